// File: doc/BRIEF.md
# Dual-Reference Clock Switchover Controller

This controller decides which of two reference clocks feeds a downstream clock consumer. It runs on a free-running monitor clock. Each reference toggles a flop in its own domain, and that flop is carried into the monitor domain through a synchronizer. When no transition arrives within a programmable number of monitor cycles, the reference is flagged as stopped. A clock mux placed after the block consumes the select output. The mux itself is not part of this block.

Three operating modes are chosen by a 2-bit mode input:

- **Automatic mode** swaps to the other reference when the selected one stops.
- **Manual mode** swaps only on a qualified switch request.
- **Override mode** combines the two. A held request in this mode freezes the selection.

After every swap, a hold-off period follows. During hold-off, automatic swapping is suppressed, so two dead references cannot make the selection thrash on every cycle.

The control core is a four-state machine:

| State | Meaning |
|---|---|
| REF0 | Reference 0 selected, settled |
| REF1 | Reference 1 selected, settled |
| HOLD0 | Reference 0 selected, hold-off running |
| HOLD1 | Reference 1 selected, hold-off running |

Its transitions are:

- **swap**: REF0 to HOLD1, and REF1 to HOLD0.
- **manual swap during hold-off**: HOLD0 to HOLD1, and HOLD1 to HOLD0.
- **hold-off expiry**: HOLD0 to REF0, and HOLD1 to REF1.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is asserted, and immediately after it, the selection is reference 0 (`sel_o`=0, `active_o`=2'b01) and both stopped flags read 0. The design is in state REF0.
- R2: `stopped_o[i]` goes to 1 once WINDOW consecutive monitor cycles pass with no synchronized transition from reference i. It returns to 0 in the cycle after a transition is seen again.
- R3: Switching is enabled in mode 2'b00 (automatic) and in mode 2'b10 (override, only while the request is low). In either case, if the selected reference is flagged stopped while the machine is in REF0 or REF1, the selection changes at the next monitor edge.
- R4: After any change of selection, no automatic change occurs for HOLDOFF monitor cycles. With both references dead, successive automatic changes are HOLDOFF+1 cycles apart.
- R5: A manual request qualifies when `sw_req` has been sampled low and then sampled high on REQ_MIN consecutive monitor edges. The selection changes on the edge after the REQ_MIN-th high sample, in modes 2'b01, 2'b10 and 2'b11, including during hold-off.
- R6: A request high for fewer than REQ_MIN consecutive samples causes no change of selection.
- R7: One qualified request produces exactly one change. The request must be sampled low before it can qualify again.
- R8: In mode 2'b00, `sw_req` has no effect on the selection.
- R9: In modes 2'b01 and 2'b11 (manual), a stopped reference never changes the selection.
- R10: In mode 2'b10, while `sw_req` is high no automatic change occurs. The qualified request itself still produces its one change. Automatic changes resume after the request falls.
- R11: Mode 2'b11 behaves exactly as manual mode 2'b01.
- R12: `active_o` is one-hot, with bit 1 equal to `sel_o` and bit 0 equal to its inverse.
- R13: A request that is already high when reset is released does not qualify until it has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 2 | The two reference clocks, index 0 and 1 |
| sw_req | input | 1 | Switch request, synchronous to `mon_clk` |
| mode | input | 2 | 00 automatic, 01 manual, 10 automatic with manual override, 11 manual |
| sel_o | output | 1 | Index of the reference that drives the consumer |
| active_o | output | 2 | One-hot flag of the active reference |
| stopped_o | output | 2 | Per-reference flag that the clock has stopped toggling |

## Verification
The bench concentrates on several corner cases, each paired with the failure it would expose:

- **Two dead references.** A design that lost or shortened the hold-off would flip the selection every cycle instead of every HOLDOFF+1 cycles.
- **Short and long requests.** A qualifier that counted one sample too few or too many would swap one edge early or late. A qualifier that did not demand a fall would swap repeatedly on a held request, or swap on a request held across reset.
- **Override mode with a held request.** A design that ignored the request as a blocker would keep bouncing between the dead clocks.
- **Manual modes with a dead selected clock.** A design that let the automatic path leak in would swap there.

A behavioural model in the bench predicts selection and stopped flags on every cycle, so any off-by-one in the detection window or the synchronizer depth shows up as a mismatch.

// File: rtl/refclk_sw_pkg.sv
`timescale 1ns/1ps
package refclk_sw_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO       = 2'b00,
        MODE_MANUAL     = 2'b01,
        MODE_OVERRIDE   = 2'b10,
        MODE_MANUAL_ALT = 2'b11
    } sw_mode_t;

    typedef enum logic [1:0] {
        ST_REF0  = 2'b00,
        ST_REF1  = 2'b01,
        ST_HOLD0 = 2'b10,
        ST_HOLD1 = 2'b11
    } sw_state_t;

endpackage

// File: rtl/refclk_activity_mon.sv
`timescale 1ns/1ps
module refclk_activity_mon #(
    parameter int WINDOW      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic mon_clk,
    input  logic rst_n,
    output logic stopped
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(WINDOW);

    logic                   tog_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [CW-1:0]          idle_q;
    logic                   edge_seen;

    // toggle flop in the reference domain
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    // synchronizer chain and change detector in the monitor domain
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= tog_q;
            for (int j = 1; j < SYNC_STAGES; j++) sync_q[j] <= sync_q[j-1];
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

    // idle counter, saturating at the window length
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n)                 idle_q <= '0;
        else if (edge_seen)         idle_q <= '0;
        else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
    end

    assign stopped = (idle_q == IDLE_MAX);

    // R2: a seen transition clears the stopped flag on the next edge
    p_stop_clears_r2: assert property (@(posedge mon_clk) disable iff (!rst_n)
        edge_seen |=> !stopped);

    // R2: the flag cannot rise while transitions keep arriving
    p_stop_needs_idle_r2: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (!stopped && edge_seen) |=> !$rose(stopped));

endmodule

// File: rtl/refclk_req_qualifier.sv
`timescale 1ns/1ps
module refclk_req_qualifier #(
    parameter int REQ_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic fire_o
);
    localparam int QW = (REQ_MIN > 1) ? $clog2(REQ_MIN + 1) : 1;
    localparam logic [QW-1:0] HI_LAST = QW'(REQ_MIN - 1);

    logic          armed_q;
    logic [QW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            hi_q    <= '0;
            fire_o  <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (!req_i) begin
                armed_q <= 1'b1;
                hi_q    <= '0;
            end else if (armed_q) begin
                if (hi_q == HI_LAST) begin
                    fire_o  <= 1'b1;
                    armed_q <= 1'b0;
                    hi_q    <= '0;
                end else begin
                    hi_q <= hi_q + 1'b1;
                end
            end
        end
    end

    // R7: one pulse per qualified request
    p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    generate
        if (REQ_MIN >= 3) begin : g_min3
            // R5: a pulse follows at least three consecutive high samples
            p_fire_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
                fire_o |-> ($past(req_i) && $past(req_i, 2) && $past(req_i, 3)));
        end
    endgenerate

endmodule

// File: rtl/refclk_switch_fsm.sv
`timescale 1ns/1ps
module refclk_switch_fsm
    import refclk_sw_pkg::*;
#(
    parameter int HOLDOFF = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       req_i,
    input  logic       fire_i,
    input  logic [1:0] stopped_i,
    output logic       sel_o,
    output logic [1:0] active_o
);
    localparam int HW = $clog2(HOLDOFF + 1);
    localparam logic [HW-1:0] HO_LAST = HW'(HOLDOFF - 1);

    sw_state_t     state_q, state_d;
    sw_mode_t      mode_e;
    logic [HW-1:0] ho_q;
    logic          auto_en, man_en, blocked;
    logic          in_ref, cur_stopped, auto_sw, man_sw, do_sw, ho_done;

    // mode decode
    always_comb begin
        mode_e = sw_mode_t'(mode_i);
        unique case (mode_e)
            MODE_AUTO:                   begin auto_en = 1'b1; man_en = 1'b0; end
            MODE_MANUAL, MODE_MANUAL_ALT: begin auto_en = 1'b0; man_en = 1'b1; end
            MODE_OVERRIDE:               begin auto_en = 1'b1; man_en = 1'b1; end
        endcase
    end

    assign blocked     = (mode_e == MODE_OVERRIDE) && req_i;
    assign in_ref      = (state_q == ST_REF0) || (state_q == ST_REF1);
    assign cur_stopped = stopped_i[sel_o];
    assign auto_sw     = auto_en && in_ref && cur_stopped && !blocked;
    assign man_sw      = man_en && fire_i;
    assign do_sw       = auto_sw || man_sw;
    assign ho_done     = (ho_q == HO_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REF0:  if (do_sw) state_d = ST_HOLD1;
            ST_REF1:  if (do_sw) state_d = ST_HOLD0;
            ST_HOLD0: if (do_sw) state_d = ST_HOLD1;
                      else if (ho_done) state_d = ST_REF0;
            ST_HOLD1: if (do_sw) state_d = ST_HOLD0;
                      else if (ho_done) state_d = ST_REF1;
        endcase
    end

    // state register and hold-off counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REF0;
            ho_q    <= '0;
        end else begin
            state_q <= state_d;
            if (do_sw)                    ho_q <= '0;
            else if (!in_ref && !ho_done) ho_q <= ho_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_REF0, ST_HOLD0: begin sel_o = 1'b0; active_o = 2'b01; end
            ST_REF1, ST_HOLD1: begin sel_o = 1'b1; active_o = 2'b10; end
        endcase
    end

    // R3: settled, automatic path enabled and selected clock dead -> swap
    p_auto_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && in_ref && stopped_i[sel_o] && !blocked) |=> (sel_o != $past(sel_o)));

    // R4: during hold-off only a manual pulse can move the selection
    p_holdoff_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ref && !(fire_i && man_en)) |=> $stable(sel_o));

    // R9: manual modes ignore stopped clocks
    p_manual_no_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[0] && !fire_i) |=> $stable(sel_o));

    // R10: a held request in override mode freezes everything but its own pulse
    p_override_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b10) && req_i && !fire_i) |=> $stable(sel_o));

    // R8: automatic mode with a live selected clock keeps its choice
    p_auto_ignores_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b00) && !stopped_i[sel_o]) |=> $stable(sel_o));

endmodule

// File: rtl/refclk_switchover.sv
`timescale 1ns/1ps
module refclk_switchover #(
    parameter int WINDOW      = 16,
    parameter int HOLDOFF     = 32,
    parameter int REQ_MIN     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       mon_clk,
    input  logic       rst_n,
    input  logic [1:0] ref_clk,
    input  logic       sw_req,
    input  logic [1:0] mode,
    output logic       sel_o,
    output logic [1:0] active_o,
    output logic [1:0] stopped_o
);
    logic fire;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_mon
            refclk_activity_mon #(
                .WINDOW      (WINDOW),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_mon (
                .ref_clk (ref_clk[i]),
                .mon_clk (mon_clk),
                .rst_n   (rst_n),
                .stopped (stopped_o[i])
            );
        end
    endgenerate

    refclk_req_qualifier #(
        .REQ_MIN (REQ_MIN)
    ) u_qual (
        .clk    (mon_clk),
        .rst_n  (rst_n),
        .req_i  (sw_req),
        .fire_o (fire)
    );

    refclk_switch_fsm #(
        .HOLDOFF (HOLDOFF)
    ) u_fsm (
        .clk       (mon_clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .req_i     (sw_req),
        .fire_i    (fire),
        .stopped_i (stopped_o),
        .sel_o     (sel_o),
        .active_o  (active_o)
    );

    // R12: exactly one reference reported active, matching the select
    p_active_match_r12: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $onehot0(active_o) && (active_o[1] == sel_o) && (active_o[0] == !sel_o));

endmodule

// File: tb/refclk_switchover_tb.sv
`timescale 1ns/1ps
module refclk_switchover_tb;
    localparam int WIN  = 16;
    localparam int HOLD = 32;
    localparam int QMIN = 3;
    localparam int SYN  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] refc = 2'b00;
    logic       req = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       sel;
    logic [1:0] active, stopped;

    int checks = 0;
    int errors = 0;

    refclk_switchover #(.WINDOW(WIN), .HOLDOFF(HOLD), .REQ_MIN(QMIN), .SYNC_STAGES(SYN)) u_dut (
        .mon_clk(clk), .rst_n(rst_n), .ref_clk(refc), .sw_req(req), .mode(mode),
        .sel_o(sel), .active_o(active), .stopped_o(stopped));

    always #10 clk = ~clk;   // 50 MHz

    // reference clock generation, on the falling monitor edge
    logic [1:0] run = 2'b00;
    int         div [2] = '{0, 0};
    int         half [2] = '{1, 2};
    logic       m_tog [2] = '{1'b0, 1'b0};

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (run[i]) begin
                if (div[i] >= half[i] - 1) begin
                    div[i] = 0;
                    if (!refc[i]) m_tog[i] = !m_tog[i];
                    refc[i] <= !refc[i];
                end else begin
                    div[i] = div[i] + 1;
                end
            end
        end
    end

    // behavioural reference model, advanced on each rising edge
    logic m_sel = 1'b0, m_hold = 1'b0, m_armed = 1'b0, m_fire = 1'b0, m_live = 1'b0;
    int   m_ho = 0, m_hi = 0;
    int   m_idle [2] = '{0, 0};
    logic m_hist [2][SYN+1];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_hold = 0; m_ho = 0; m_armed = 0; m_hi = 0; m_fire = 0; m_live = 0;
            for (int i = 0; i < 2; i++) begin
                m_idle[i] = 0; m_tog[i] = 0;
                for (int j = 0; j <= SYN; j++) m_hist[i][j] = 0;
            end
        end else begin
            logic auto_m, man_m, blk, aut, nf, e;
            auto_m = (mode == 2'b00) || (mode == 2'b10);
            man_m  = m_fire && (mode != 2'b00);
            blk    = (mode == 2'b10) && req;
            aut    = auto_m && !m_hold && (m_idle[m_sel] == WIN) && !blk;
            if (man_m || aut) begin
                m_sel = !m_sel; m_hold = 1; m_ho = 0;
            end else if (m_hold) begin
                if (m_ho == HOLD - 1) m_hold = 0;
                else m_ho = m_ho + 1;
            end
            nf = 0;
            if (!req) begin
                m_armed = 1; m_hi = 0;
            end else if (m_armed) begin
                if (m_hi == QMIN - 1) begin nf = 1; m_armed = 0; m_hi = 0; end
                else m_hi = m_hi + 1;
            end
            m_fire = nf;
            for (int i = 0; i < 2; i++) begin
                e = m_hist[i][SYN-1] ^ m_hist[i][SYN];
                for (int j = SYN; j > 0; j--) m_hist[i][j] = m_hist[i][j-1];
                m_hist[i][0] = m_tog[i];
                if (e) m_idle[i] = 0;
                else if (m_idle[i] != WIN) m_idle[i] = m_idle[i] + 1;
            end
            m_live = 1;
        end
    end

    // per-cycle comparison and hold-off gap monitor
    logic gap_en = 1'b0;
    logic prev_sel = 1'b0;
    int   since = 0;
    int   n_chg = 0;

    always @(negedge clk) begin
        #2;
        if (rst_n && m_live) begin
            logic [1:0] exp_stop;
            exp_stop = {m_idle[1] == WIN, m_idle[0] == WIN};
            checks++;
            if (sel !== m_sel) begin
                errors++;
                $display("FAIL R3 R5 R10 sel actual=%0b expected=%0b at %0t", sel, m_sel, $time);
            end
            checks++;
            if (active !== {sel, ~sel} || $countones(active) != 1) begin
                errors++;
                $display("FAIL R12 active actual=%b expected=%b", active, {sel, ~sel});
            end
            checks++;
            if (stopped !== exp_stop) begin
                errors++;
                $display("FAIL R2 stopped actual=%b expected=%b at %0t", stopped, exp_stop, $time);
            end
            if (sel !== prev_sel) begin
                n_chg++;
                if (gap_en) begin
                    checks++;
                    if (since < HOLD) begin
                        errors++;
                        $display("FAIL R4 gap actual=%0d expected>=%0d", since, HOLD);
                    end
                end
                since = 0;
            end else begin
                since++;
            end
            prev_sel = sel;
        end else begin
            prev_sel = 1'b0;
            since = 0;
        end
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic s0;
        cyc(4);
        chk("R1 sel in reset", {1'b0, sel}, 2'b00);
        chk("R1 active in reset", active, 2'b01);
        chk("R1 stopped in reset", stopped, 2'b00);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 sel after reset", {1'b0, sel}, 2'b00);
        run = 2'b11;
        cyc(40);
        chk("R2 both live", stopped, 2'b00);

        // R6: short request
        req = 1'b1; cyc(2); req = 1'b0; cyc(5);
        chk("R6 short request", {1'b0, sel}, 2'b00);

        // R5: qualified request, swap on the edge after the third sample
        req = 1'b1; cyc(3);
        chk("R5 not yet", {1'b0, sel}, 2'b00);
        cyc(1);
        chk("R5 swapped", {1'b0, sel}, 2'b01);
        cyc(10);
        chk("R7 held request no second swap", {1'b0, sel}, 2'b01);
        req = 1'b0; cyc(3);

        // R9: manual mode, selected clock dies
        run[1] = 1'b0; cyc(WIN + 10);
        chk("R2 ref1 flagged", stopped, 2'b10);
        chk("R9 manual keeps dead clock", {1'b0, sel}, 2'b01);

        // R11: mode 3 behaves as manual
        mode = 2'b11; cyc(5);
        chk("R11 no auto swap", {1'b0, sel}, 2'b01);
        req = 1'b1; cyc(4);
        chk("R11 manual swap", {1'b0, sel}, 2'b00);
        req = 1'b0;
        run[1] = 1'b1; cyc(10);
        chk("R2 ref1 recovered", stopped, 2'b00);

        // R8: automatic mode ignores requests
        mode = 2'b00; cyc(2);
        req = 1'b1; cyc(6); req = 1'b0; cyc(40);
        chk("R8 request ignored", {1'b0, sel}, 2'b00);

        // R3: selected clock dies in automatic mode
        run[0] = 1'b0; cyc(WIN + SYN + 6);
        chk("R3 auto swap", {1'b0, sel}, 2'b01);
        chk("R2 ref0 flagged", stopped, 2'b01);

        // R4: both dead, bouncing paced by hold-off
        gap_en = 1'b1;
        run[1] = 1'b0; cyc(220);
        gap_en = 1'b0;
        chk("R2 both flagged", stopped, 2'b11);

        // R10: override mode with held request
        mode = 2'b10; cyc(1);
        req = 1'b1; cyc(3);
        s0 = sel;
        cyc(1);
        chk("R10 manual swap in override", {1'b0, sel}, {1'b0, ~s0});
        s0 = sel;
        cyc(150);
        chk("R10 frozen while held", {1'b0, sel}, {1'b0, s0});
        req = 1'b0;
        n_chg = 0;
        cyc(100);
        chk("R10 auto resumes", {1'b0, n_chg > 0}, 2'b01);

        // R13: request high across reset
        run = 2'b00; mode = 2'b01; cyc(3);
        req = 1'b1; cyc(1);
        rst_n = 1'b0; cyc(4);
        chk("R1 reset again", {1'b0, sel}, 2'b00);
        rst_n = 1'b1; cyc(1);
        run = 2'b11; cyc(10);
        chk("R13 held request ignored", {1'b0, sel}, 2'b00);
        req = 1'b0; cyc(1);
        req = 1'b1; cyc(4);
        chk("R5 R13 qualifies after fall", {1'b0, sel}, 2'b01);
        req = 1'b0; cyc(5);

        summary();
        $finish;
    end
endmodule